// File: doc/BRIEF.md
# Shared-Channel Reconfiguration Arbiter

This block sits between two reconfiguration managers, one serving the receive half and one serving the transmit half of a single physical transceiver channel, and the one reconfiguration port of that channel. The port accepts only one memory-mapped access at a time. The arbiter gives the port to one manager at a time and keeps it there until that manager's sequence is finished. It routes read data and wait-request from the matching transceiver path back to the manager that holds the port.

A second job is to keep the two halves from calibrating at the same time. Each side's calibration-busy indication goes to that side's reset controller. While one side owns the channel, the other side's indication is forced high, so its reset controller waits. The owner's own indication passes straight through.

Arbitration is round-robin when both sides ask in the same cycle. A side that asks alone is granted without delay. Both managers and the arbiter share one clock and one active-low synchronous reset.

Top module: `reconfig_arbiter`

## Requirements
- R1: After reset no side owns the port. Both wait-request outputs read 1, and each calibration-busy output equals its own transceiver input.
- R2: A side raises a request by driving its enable, write or read high. If it asks alone while the port is free, it owns the port from the next clock edge. From then on, its write, read, address, write data and channel select appear unchanged on the merged port.
- R3: If both sides ask in the same cycle while the port is free, the side not granted most recently wins. The first such tie after reset goes to the receive side.
- R4: Ownership is held as long as the owner's enable, write, read or own transceiver calibration-busy is high. During that time the other side's commands do not reach the merged port.
- R5: Ownership is released on the first edge at which all four of the owner's holding signals are low. If the other side is asking at that edge, it becomes owner on that same edge.
- R6: The owner receives its own path's read data and wait-request. A side that does not own the port sees read data 0 and wait-request 1.
- R7: While one side owns the port, the other side's calibration-busy output is 1. The owner's calibration-busy output follows its own transceiver input. With no owner, both outputs pass through.
- R8: With no owner, merged write and read are 0, and address, write data and channel select are 0.
- R9: At most one side is selected in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Synchronous reset, active low |
| rxEnable | input | 1 | Receive manager reconfiguration enable |
| rxChanSel | input | 2 | Receive manager target channel |
| rxWrite | input | 1 | Receive manager write strobe |
| rxRead | input | 1 | Receive manager read strobe |
| rxAddr | input | 10 | Receive manager address |
| rxWdata | input | 32 | Receive manager write data |
| rxRdata | output | 32 | Read data to receive manager |
| rxWaitreq | output | 1 | Wait-request to receive manager |
| txEnable | input | 1 | Transmit manager reconfiguration enable |
| txChanSel | input | 2 | Transmit manager target channel |
| txWrite | input | 1 | Transmit manager write strobe |
| txRead | input | 1 | Transmit manager read strobe |
| txAddr | input | 10 | Transmit manager address |
| txWdata | input | 32 | Transmit manager write data |
| txRdata | output | 32 | Read data to transmit manager |
| txWaitreq | output | 1 | Wait-request to transmit manager |
| mWrite | output | 1 | Merged write to transceiver port |
| mRead | output | 1 | Merged read to transceiver port |
| mAddr | output | 10 | Merged address |
| mWdata | output | 32 | Merged write data |
| mChanSel | output | 2 | Channel select of the owner |
| xcvrRxRdata | input | 32 | Read data from the receive path |
| xcvrRxWaitreq | input | 1 | Wait-request from the receive path |
| xcvrTxRdata | input | 32 | Read data from the transmit path |
| xcvrTxWaitreq | input | 1 | Wait-request from the transmit path |
| xcvrRxCalBusy | input | 1 | Receive half calibration busy |
| xcvrTxCalBusy | input | 1 | Transmit half calibration busy |
| rxCalBusyOut | output | 1 | Calibration busy toward receive reset controller |
| txCalBusyOut | output | 1 | Calibration busy toward transmit reset controller |

## Verification
Two functions can act on the same clock edge: the release of the current owner and the grant to the waiting side. The case that tests this has one side still asking while the owner drops its last holding signal, which is its own calibration-busy. The bench then checks on the next cycle that the waiting side owns the port with no idle cycle in between. It also checks that the former owner at once sees wait-request 1 and a forced calibration-busy. A second case raises both requests in the same cycle several times in a row, and the grant must alternate between the sides each time.

// File: rtl/reconfig_arb_pkg.sv
package reconfig_arb_pkg;
  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_RX = 2'd1, OWN_TX = 2'd2} owner_e;

  typedef struct packed {
    logic selRx;
    logic selTx;
  } arbCtrl_t;
endpackage

// File: rtl/reconfig_arb_ctrl.sv
module reconfig_arb_ctrl
  import reconfig_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxReq,
  input  logic     txReq,
  input  logic     rxCal,
  input  logic     txCal,
  output arbCtrl_t ctrl
);
  owner_e owner, ownerNext;
  logic   lastWasTx;
  logic   rxBusy, txBusy;

  always_comb begin
    rxBusy    = rxReq | rxCal;
    txBusy    = txReq | txCal;
    ownerNext = owner;
    case (owner)
      OWN_RX:  if (!rxBusy) ownerNext = txReq ? OWN_TX : OWN_NONE;
      OWN_TX:  if (!txBusy) ownerNext = rxReq ? OWN_RX : OWN_NONE;
      default: begin
        if (rxReq && txReq) ownerNext = lastWasTx ? OWN_RX : OWN_TX;
        else if (rxReq)     ownerNext = OWN_RX;
        else if (txReq)     ownerNext = OWN_TX;
        else                ownerNext = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner     <= OWN_NONE;
      lastWasTx <= 1'b1;
    end else begin
      owner <= ownerNext;
      if (ownerNext == OWN_RX)      lastWasTx <= 1'b0;
      else if (ownerNext == OWN_TX) lastWasTx <= 1'b1;
    end
  end

  always_comb begin
    ctrl.selRx = (owner == OWN_RX);
    ctrl.selTx = (owner == OWN_TX);
  end
endmodule

// File: rtl/reconfig_arb_datapath.sv
module reconfig_arb_datapath
  import reconfig_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CHSEL_W = 2
) (
  input  arbCtrl_t             ctrl,
  input  logic                 rxWrite,
  input  logic                 rxRead,
  input  logic [ADDR_W-1:0]    rxAddr,
  input  logic [DATA_W-1:0]    rxWdata,
  input  logic [CHSEL_W-1:0]   rxChanSel,
  input  logic                 txWrite,
  input  logic                 txRead,
  input  logic [ADDR_W-1:0]    txAddr,
  input  logic [DATA_W-1:0]    txWdata,
  input  logic [CHSEL_W-1:0]   txChanSel,
  input  logic [DATA_W-1:0]    xcvrRxRdata,
  input  logic                 xcvrRxWaitreq,
  input  logic [DATA_W-1:0]    xcvrTxRdata,
  input  logic                 xcvrTxWaitreq,
  input  logic                 xcvrRxCalBusy,
  input  logic                 xcvrTxCalBusy,
  output logic                 mWrite,
  output logic                 mRead,
  output logic [ADDR_W-1:0]    mAddr,
  output logic [DATA_W-1:0]    mWdata,
  output logic [CHSEL_W-1:0]   mChanSel,
  output logic [DATA_W-1:0]    rxRdata,
  output logic                 rxWaitreq,
  output logic [DATA_W-1:0]    txRdata,
  output logic                 txWaitreq,
  output logic                 rxCalBusyOut,
  output logic                 txCalBusyOut
);
  localparam int CMD_W = 2 + ADDR_W + DATA_W + CHSEL_W;

  logic [CMD_W-1:0] rxCmd, txCmd, mCmd;

  always_comb begin
    rxCmd = {rxWrite, rxRead, rxAddr, rxWdata, rxChanSel};
    txCmd = {txWrite, txRead, txAddr, txWdata, txChanSel};
    if (ctrl.selRx)      mCmd = rxCmd;
    else if (ctrl.selTx) mCmd = txCmd;
    else                 mCmd = '0;
    {mWrite, mRead, mAddr, mWdata, mChanSel} = mCmd;

    rxRdata   = ctrl.selRx ? xcvrRxRdata : '0;
    rxWaitreq = ctrl.selRx ? xcvrRxWaitreq : 1'b1;
    txRdata   = ctrl.selTx ? xcvrTxRdata : '0;
    txWaitreq = ctrl.selTx ? xcvrTxWaitreq : 1'b1;

    rxCalBusyOut = ctrl.selTx | xcvrRxCalBusy;
    txCalBusyOut = ctrl.selRx | xcvrTxCalBusy;
  end
endmodule

// File: rtl/reconfig_arbiter.sv
module reconfig_arbiter
  import reconfig_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CHSEL_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxEnable,
  input  logic [CHSEL_W-1:0] rxChanSel,
  input  logic               rxWrite,
  input  logic               rxRead,
  input  logic [ADDR_W-1:0]  rxAddr,
  input  logic [DATA_W-1:0]  rxWdata,
  output logic [DATA_W-1:0]  rxRdata,
  output logic               rxWaitreq,
  input  logic               txEnable,
  input  logic [CHSEL_W-1:0] txChanSel,
  input  logic               txWrite,
  input  logic               txRead,
  input  logic [ADDR_W-1:0]  txAddr,
  input  logic [DATA_W-1:0]  txWdata,
  output logic [DATA_W-1:0]  txRdata,
  output logic               txWaitreq,
  output logic               mWrite,
  output logic               mRead,
  output logic [ADDR_W-1:0]  mAddr,
  output logic [DATA_W-1:0]  mWdata,
  output logic [CHSEL_W-1:0] mChanSel,
  input  logic [DATA_W-1:0]  xcvrRxRdata,
  input  logic               xcvrRxWaitreq,
  input  logic [DATA_W-1:0]  xcvrTxRdata,
  input  logic               xcvrTxWaitreq,
  input  logic               xcvrRxCalBusy,
  input  logic               xcvrTxCalBusy,
  output logic               rxCalBusyOut,
  output logic               txCalBusyOut
);
  arbCtrl_t ctrl;
  logic     rxReq, txReq;

  assign rxReq = rxEnable | rxWrite | rxRead;
  assign txReq = txEnable | txWrite | txRead;

  reconfig_arb_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .rxReq (rxReq),
    .txReq (txReq),
    .rxCal (xcvrRxCalBusy),
    .txCal (xcvrTxCalBusy),
    .ctrl  (ctrl)
  );

  reconfig_arb_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CHSEL_W(CHSEL_W)
  ) dp_i (
    .ctrl          (ctrl),
    .rxWrite       (rxWrite),
    .rxRead        (rxRead),
    .rxAddr        (rxAddr),
    .rxWdata       (rxWdata),
    .rxChanSel     (rxChanSel),
    .txWrite       (txWrite),
    .txRead        (txRead),
    .txAddr        (txAddr),
    .txWdata       (txWdata),
    .txChanSel     (txChanSel),
    .xcvrRxRdata   (xcvrRxRdata),
    .xcvrRxWaitreq (xcvrRxWaitreq),
    .xcvrTxRdata   (xcvrTxRdata),
    .xcvrTxWaitreq (xcvrTxWaitreq),
    .xcvrRxCalBusy (xcvrRxCalBusy),
    .xcvrTxCalBusy (xcvrTxCalBusy),
    .mWrite        (mWrite),
    .mRead         (mRead),
    .mAddr         (mAddr),
    .mWdata        (mWdata),
    .mChanSel      (mChanSel),
    .rxRdata       (rxRdata),
    .rxWaitreq     (rxWaitreq),
    .txRdata       (txRdata),
    .txWaitreq     (txWaitreq),
    .rxCalBusyOut  (rxCalBusyOut),
    .txCalBusyOut  (txCalBusyOut)
  );
endmodule

// File: rtl/reconfig_arb_checker.sv
module reconfig_arb_checker
  import reconfig_arb_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input arbCtrl_t ctrl,
  input logic     rxReq,
  input logic     txReq,
  input logic     xcvrRxCalBusy,
  input logic     rxCalBusyOut,
  input logic     txCalBusyOut,
  input logic     rxWaitreq,
  input logic     txWaitreq,
  input logic     mWrite,
  input logic     mRead
);
  assert_one_owner_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.selRx, ctrl.selTx}));

  assert_hold_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.selRx && (rxReq || xcvrRxCalBusy)) |=> ctrl.selRx);

  assert_lone_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.selRx && !ctrl.selTx && rxReq && !txReq) |=> ctrl.selRx);

  assert_gate_tx_cal_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selRx |-> txCalBusyOut);

  assert_gate_rx_cal_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selTx |-> rxCalBusyOut);

  assert_stall_loser_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.selTx |-> txWaitreq) and (!ctrl.selRx |-> rxWaitreq));

  assert_idle_port_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.selRx && !ctrl.selTx) |-> (!mWrite && !mRead));
endmodule

bind reconfig_arbiter reconfig_arb_checker chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .ctrl          (ctrl),
  .rxReq         (rxReq),
  .txReq         (txReq),
  .xcvrRxCalBusy (xcvrRxCalBusy),
  .rxCalBusyOut  (rxCalBusyOut),
  .txCalBusyOut  (txCalBusyOut),
  .rxWaitreq     (rxWaitreq),
  .txWaitreq     (txWaitreq),
  .mWrite        (mWrite),
  .mRead         (mRead)
);

// File: tb/reconfig_arbiter_tb.sv
module reconfig_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        rxEnable, rxWrite, rxRead, txEnable, txWrite, txRead;
  logic [1:0]  rxChanSel, txChanSel, mChanSel;
  logic [9:0]  rxAddr, txAddr, mAddr;
  logic [31:0] rxWdata, txWdata, rxRdata, txRdata, mWdata;
  logic [31:0] xcvrRxRdata, xcvrTxRdata;
  logic        rxWaitreq, txWaitreq, mWrite, mRead;
  logic        xcvrRxWaitreq, xcvrTxWaitreq, xcvrRxCalBusy, xcvrTxCalBusy;
  logic        rxCalBusyOut, txCalBusyOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  reconfig_arbiter dut_i (.*);

  localparam logic [9:0]  RX_A = 10'h1A5, TX_A = 10'h2C3;
  localparam logic [31:0] RX_D = 32'hA5A5_0001, TX_D = 32'h5A5A_0002;

  // {rxEn, txEn, rxWr, txWr, rxCal, txCal, expectedOwner(0 none,1 rx,2 tx)}
  localparam int NV = 16;
  localparam logic [7:0] VEC [NV] = '{
    8'b000000_00, 8'b100000_01, 8'b110000_01, 8'b011000_01,
    8'b010010_01, 8'b010000_10, 8'b010100_10, 8'b000000_00,
    8'b110000_01, 8'b000000_00, 8'b110000_10, 8'b000000_00,
    8'b010000_10, 8'b000000_00, 8'b110000_01, 8'b000000_00
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    rxEnable = 0; rxWrite = 0; rxRead = 0; txEnable = 0; txWrite = 0; txRead = 0;
    rxChanSel = 2'd1; txChanSel = 2'd2;
    rxAddr = RX_A; txAddr = TX_A; rxWdata = RX_D; txWdata = TX_D;
    xcvrRxRdata = 32'hDEAD_BEEF; xcvrTxRdata = 32'h1234_5678;
    xcvrRxWaitreq = 0; xcvrTxWaitreq = 0; xcvrRxCalBusy = 0; xcvrTxCalBusy = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    idleInputs();
    xcvrRxCalBusy = 1;
    doReset();
    // R1: reset state
    chk("R1 rxWaitreq", {31'd0, rxWaitreq}, 32'd1);
    chk("R1 txWaitreq", {31'd0, txWaitreq}, 32'd1);
    chk("R1 rxCalBusyOut passthrough", {31'd0, rxCalBusyOut}, 32'd1);
    chk("R1 txCalBusyOut passthrough", {31'd0, txCalBusyOut}, 32'd0);
    chk("R8 idle port", {20'd0, mWrite, mRead, mAddr}, 32'd0);
    xcvrRxCalBusy = 0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] sel;
      {rxEnable, txEnable, rxWrite, txWrite, xcvrRxCalBusy, xcvrTxCalBusy, sel} = VEC[i];
      @(posedge clk); #1;
      chk("R2 mAddr", {22'd0, mAddr}, sel == 1 ? {22'd0, RX_A} : sel == 2 ? {22'd0, TX_A} : 32'd0);
      chk("R4 mWrite", {31'd0, mWrite}, sel == 1 ? {31'd0, rxWrite} : sel == 2 ? {31'd0, txWrite} : 32'd0);
      chk("R6 rxWaitreq", {31'd0, rxWaitreq}, sel == 1 ? 32'd0 : 32'd1);
      chk("R6 txWaitreq", {31'd0, txWaitreq}, sel == 2 ? 32'd0 : 32'd1);
      chk("R7 rxCalBusyOut", {31'd0, rxCalBusyOut}, sel == 2 ? 32'd1 : {31'd0, xcvrRxCalBusy});
      chk("R7 txCalBusyOut", {31'd0, txCalBusyOut}, sel == 1 ? 32'd1 : {31'd0, xcvrTxCalBusy});
    end

    // R3: first tie after reset goes to the receive side
    idleInputs();
    doReset();
    rxEnable = 1; txEnable = 1;
    @(posedge clk); #1;
    chk("R3 first tie rx", {22'd0, mAddr}, {22'd0, RX_A});

    // R6/R2: read steering and full command pass-through for rx
    rxEnable = 1; txEnable = 0; rxRead = 1; xcvrRxWaitreq = 1;
    @(posedge clk); #1;
    chk("R2 mRead", {31'd0, mRead}, 32'd1);
    chk("R2 mWdata", mWdata, RX_D);
    chk("R2 mChanSel", {30'd0, mChanSel}, 32'd1);
    chk("R6 rx waitreq follows path", {31'd0, rxWaitreq}, 32'd1);
    chk("R6 rxRdata", rxRdata, 32'hDEAD_BEEF);
    chk("R6 txRdata blocked", txRdata, 32'd0);
    xcvrRxWaitreq = 0;
    #1 chk("R6 rx waitreq released", {31'd0, rxWaitreq}, 32'd0);

    // R5: handoff on the edge the owner's own calibration ends
    rxEnable = 0; rxRead = 0; xcvrRxCalBusy = 1; txEnable = 1; txWrite = 1;
    @(posedge clk); #1;
    chk("R4 held by rx cal", {31'd0, txWaitreq}, 32'd1);
    chk("R4 tx write blocked", {31'd0, mWrite}, 32'd0);
    xcvrRxCalBusy = 0;
    @(posedge clk); #1;
    chk("R5 handoff tx", {22'd0, mAddr}, {22'd0, TX_A});
    chk("R5 tx write passes", {31'd0, mWrite}, 32'd1);
    chk("R6 txRdata", txRdata, 32'h1234_5678);
    chk("R6 rx stalled", {31'd0, rxWaitreq}, 32'd1);
    chk("R7 rx cal forced", {31'd0, rxCalBusyOut}, 32'd1);

    // R1: reset mid-ownership clears owner
    doReset();
    chk("R1 reset clears owner", {31'd0, txWaitreq}, 32'd1);
    chk("R8 port cleared", {31'd0, mWrite}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule